// File: doc/BRIEF.md
# Pulse-Coded Command Packet Receiver

This block collects 16-byte command packets that a processor sends over two select lines, which are also its keypad-port select bits. Each write to the port hands the receiver a new 2-bit line state. A run of line-state changes encodes the packet. Pulling both lines low restarts the packet. A one-pulse or a zero-pulse marks the value of the current bit. A return to the idle state (both lines high) moves to the next bit. Once all 128 bits have been delivered, a final zero-pulse hands the whole packet to the consumer with a single-cycle valid strobe.

After the packet has been handed over, the processor can send a further short pulse sequence to step a multi-controller index. The index advances by one, wrapped by a controller-count mask that is supplied at the input. What the packet means is decided downstream; this block only assembles the bits and steps the index.

Top module: `pulse_pkt_rx`

## Requirements
- R1: After reset, `pktValid` is 0, `ctrlIdx` is 0 and `pktData` is all zeros. The bit pointer starts at -1.
- R2: A write of line state 2'b00 sets the bit pointer to -1 and clears every bit of the packet buffer. A packet emitted afterwards carries none of the bits set before the clear.
- R3: A write whose line state equals the last accepted line state has no effect. Line state 2'b00 is the one exception: it still applies the clear of R2.
- R4: Line state 2'b01 sets the buffer bit at the pointer to 1, but only when the pointer is 0 to 127. When the pointer is -1 it does nothing. Bits that are never set stay 0.
- R5: Line state 2'b11 adds one to the pointer while the pointer is below 128.
- R6: Buffer bit k, for pointer value k, appears at `pktData[k]`. Byte k>>3 of the packet occupies `pktData[8*(k>>3)+7 : 8*(k>>3)]`, and bit k&7 is the bit inside that byte, so the packet is sent least significant bit first.
- R7: Line state 2'b10 with the pointer at exactly 128 loads the buffer into `pktData` and sets the pointer to 129. `pktData` holds that value until the next emit.
- R8: While the pointer is above 128, the line states act as follows:
  - 2'b01 ORs 2 into the pointer.
  - 2'b10 ORs 4 into the pointer.
  - 2'b11 with the pointer at exactly 135 clears pointer bits 2:1 and sets `ctrlIdx` to (`ctrlIdx`+1) AND `idxMask`.
  
  No buffer bit changes in this range.
- R9: The last accepted line state resets to 2'b11, so an idle write straight after reset does not move the pointer.
- R10: `pktValid` is high for exactly one clock per emit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | A port write is presented this cycle |
| lineState | input | 2 | Select-line state carried by the write |
| idxMask | input | IDX_W | Controller-count mask applied when the index steps |
| pktData | output | PKT_BYTES*8 | Last completed packet, least significant bit first |
| pktValid | output | 1 | One-cycle strobe when `pktData` is updated |
| ctrlIdx | output | IDX_W | Current controller index |

## Verification
The bench targets the following corner cases:
- **Dead pointer position.** A one-pulse at pointer -1 and an idle right after reset must both leave the buffer alone. A design that got either wrong would emit a packet shifted by one bit.
- **Repeated line states.** These are injected between real pulses. A receiver that counted them would advance twice and misplace every later bit.
- **Emit and post-packet sequence.** The bench checks the exact emit condition at pointer 128. It then checks the OR-into-pointer sequence that steps the index under masks 0, 1 and 3. A wrong mask or a wrong clear of pointer bits would show up at once as a stuck or runaway `ctrlIdx`.
- **Mid-packet reset pulse.** A reset pulse in the middle of a packet must wipe the bits already sent. Otherwise stale ones would leak into the next packet.

// File: rtl/pulse_pkt_rx_pkg.sv
package pulse_pkt_rx_pkg;

  // Select-line states carried by a port write
  typedef enum logic [1:0] {
    LS_RESET = 2'b00,
    LS_ONE   = 2'b01,
    LS_ZERO  = 2'b10,
    LS_IDLE  = 2'b11
  } line_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrBuf;
    logic setBit;
    logic emit;
  } rx_strobe_t;

endpackage

// File: rtl/pulse_pkt_rx_ctrl.sv
module pulse_pkt_rx_ctrl
  import pulse_pkt_rx_pkg::*;
#(
  parameter int PKT_BITS = 128,
  parameter int IDX_W    = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [1:0]                  lineState,
  input  logic [IDX_W-1:0]            idxMask,
  output rx_strobe_t                  strb,
  output logic [$clog2(PKT_BITS)-1:0] bitSel,
  output logic [IDX_W-1:0]            ctrlIdx
);

  localparam int SEL_W = $clog2(PKT_BITS);
  localparam int PTR_W = SEL_W + 2;
  localparam logic signed [PTR_W-1:0] PTR_NONE  = '1;
  localparam logic signed [PTR_W-1:0] STOP_PT   = PTR_W'(PKT_BITS);
  localparam logic signed [PTR_W-1:0] AFTER_PT  = PTR_W'(PKT_BITS + 1);
  localparam logic signed [PTR_W-1:0] PAIR_PT   = PTR_W'(PKT_BITS + 7);
  localparam logic [PTR_W-1:0]        OR_ONE    = PTR_W'(2);
  localparam logic [PTR_W-1:0]        OR_ZERO   = PTR_W'(4);
  localparam logic [PTR_W-1:0]        PAIR_CLR  = PTR_W'(6);

  logic signed [PTR_W-1:0] bitPtr, ptrNext, work;
  logic [1:0]              lastState, lastNext;
  logic [IDX_W-1:0]        idxNext;

  always_comb begin
    strb     = '0;
    bitSel   = '0;
    work     = bitPtr;
    lastNext = lastState;
    idxNext  = ctrlIdx;
    if (wrEn) begin
      if (lineState == LS_RESET) begin
        work        = PTR_NONE;
        strb.clrBuf = 1'b1;
      end
      if (lineState != lastState) begin
        lastNext = lineState;
        if (work > STOP_PT) begin
          // post-packet controller-step sequence
          case (lineState)
            LS_ONE:  work = work | OR_ONE;
            LS_ZERO: work = work | OR_ZERO;
            LS_IDLE: begin
              if (work == PAIR_PT) begin
                work    = work & ~PAIR_CLR;
                idxNext = (ctrlIdx + 1'b1) & idxMask;
              end
            end
            default: ;
          endcase
        end else if (work == STOP_PT) begin
          if (lineState == LS_ZERO) begin
            strb.emit = 1'b1;
            work      = AFTER_PT;
          end
        end else if (lineState == LS_ONE) begin
          if (work >= 0) begin
            strb.setBit = 1'b1;
            bitSel      = work[SEL_W-1:0];
          end
        end else if (lineState == LS_IDLE) begin
          work = work + PTR_W'(1);
        end
      end
    end
    ptrNext = work;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPtr    <= PTR_NONE;
      lastState <= LS_IDLE;
      ctrlIdx   <= '0;
    end else begin
      bitPtr    <= ptrNext;
      lastState <= lastNext;
      ctrlIdx   <= idxNext;
    end
  end

  // R5 / R8: pointer never leaves -1 .. PKT_BITS+7
  a_r5_ptr_bounds: assert property (@(posedge clk) disable iff (!rstN)
    (bitPtr >= PTR_NONE) && (bitPtr <= PAIR_PT));

  // R3: a repeated non-reset state leaves pointer and index alone
  a_r3_repeat_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && lineState == lastState && lineState != LS_RESET)
      |=> ($stable(bitPtr) && $stable(ctrlIdx)));

  // R7: an emit leaves the pointer just past the stop position
  a_r7_emit_ptr: assert property (@(posedge clk) disable iff (!rstN)
    strb.emit |=> (bitPtr == AFTER_PT));

  // R8: the index only ever moves by one step under the mask
  a_r8_idx_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIdx != $past(ctrlIdx))
      |-> (ctrlIdx == (($past(ctrlIdx) + 1'b1) & $past(idxMask))));

  // R2: a reset pulse always returns the pointer to -1
  a_r2_reset_ptr: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && lineState == LS_RESET) |=> (bitPtr == PTR_NONE));

endmodule

// File: rtl/pulse_pkt_rx_datapath.sv
module pulse_pkt_rx_datapath
  import pulse_pkt_rx_pkg::*;
#(
  parameter int PKT_BYTES = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  rx_strobe_t                       strb,
  input  logic [$clog2(PKT_BYTES*8)-1:0]   bitSel,
  output logic [PKT_BYTES*8-1:0]           pktData,
  output logic                             pktValid
);

  localparam int PKT_BITS = PKT_BYTES * 8;
  localparam int SEL_W    = $clog2(PKT_BITS);
  localparam int BYTE_W   = SEL_W - 3;

  logic [PKT_BITS-1:0] bufBits;

  // One byte lane per packet byte; the upper select bits pick the lane
  for (genvar b = 0; b < PKT_BYTES; b++) begin : g_lane
    logic [7:0] laneQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneQ <= '0;
      end else if (strb.clrBuf) begin
        laneQ <= '0;
      end else if (strb.setBit && bitSel[SEL_W-1:3] == BYTE_W'(b)) begin
        laneQ[bitSel[2:0]] <= 1'b1;
      end
    end
    assign bufBits[b*8 +: 8] = laneQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktData  <= '0;
      pktValid <= 1'b0;
    end else begin
      pktValid <= strb.emit;
      if (strb.emit) pktData <= bufBits;
    end
  end

  // R10: a valid strobe never lasts two cycles
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |=> !pktValid);

  // R2: a clear strobe empties the buffer
  a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrBuf |=> (bufBits == '0));

  // R7: the output holds between emits
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.emit |=> $stable(pktData));

endmodule

// File: rtl/pulse_pkt_rx.sv
module pulse_pkt_rx
  import pulse_pkt_rx_pkg::*;
#(
  parameter int PKT_BYTES = 16,
  parameter int IDX_W     = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [1:0]             lineState,
  input  logic [IDX_W-1:0]       idxMask,
  output logic [PKT_BYTES*8-1:0] pktData,
  output logic                   pktValid,
  output logic [IDX_W-1:0]       ctrlIdx
);

  localparam int PKT_BITS = PKT_BYTES * 8;
  localparam int SEL_W    = $clog2(PKT_BITS);

  rx_strobe_t       strb;
  logic [SEL_W-1:0] bitSel;

  pulse_pkt_rx_ctrl #(.PKT_BITS(PKT_BITS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .lineState(lineState),
    .idxMask(idxMask), .strb(strb), .bitSel(bitSel), .ctrlIdx(ctrlIdx)
  );

  pulse_pkt_rx_datapath #(.PKT_BYTES(PKT_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitSel(bitSel),
    .pktData(pktData), .pktValid(pktValid)
  );

endmodule

// File: tb/pulse_pkt_rx_test.sv
`timescale 1ns/1ps
module pulse_pkt_rx_test;
  localparam int PB = 16;
  localparam int NB = PB * 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [1:0]    lineState = 2'b11;
  logic [1:0]    idxMask = 2'b11;
  logic [NB-1:0] pktData;
  logic          pktValid;
  logic [1:0]    ctrlIdx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // bench reference state
  int          mPtr = -1;
  logic [NB-1:0] mBuf = '0;
  logic [NB-1:0] mPkt = '0;
  logic [1:0]  mLast = 2'b11;
  int          mIdx = 0;
  bit          mValid = 0;

  always #4 clk = ~clk;

  pulse_pkt_rx #(.PKT_BYTES(PB), .IDX_W(2)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .lineState(lineState),
    .idxMask(idxMask), .pktData(pktData), .pktValid(pktValid), .ctrlIdx(ctrlIdx)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: run did not end (actual cycles %0d, expected under 190000)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected behaviour of one accepted write, from the requirements
  task automatic modelWrite(input logic [1:0] s);
    mValid = 0;
    if (s == 2'b00) begin mPtr = -1; mBuf = '0; end        // R2
    if (s != mLast) begin                                 // R3
      mLast = s;
      if (mPtr > NB) begin                                // R8
        if (s == 2'b01) mPtr = mPtr | 2;
        else if (s == 2'b10) mPtr = mPtr | 4;
        else if (s == 2'b11 && mPtr == NB + 7) begin
          mPtr = mPtr & ~6;
          mIdx = (mIdx + 1) & int'(idxMask);
        end
      end else if (mPtr == NB) begin
        if (s == 2'b10) begin mValid = 1; mPkt = mBuf; mPtr = NB + 1; end  // R7
      end else if (s == 2'b01) begin
        if (mPtr >= 0) mBuf[mPtr] = 1'b1;                 // R4, R6
      end else if (s == 2'b11) begin
        mPtr++;                                           // R5
      end
    end
  endtask

  task automatic doWrite(input logic [1:0] s, input string req);
    @(negedge clk);
    wrEn = 1'b1;
    lineState = s;
    modelWrite(s);
    @(negedge clk);
    wrEn = 1'b0;
    chk({req, " valid"}, NB'(pktValid), NB'(mValid));
    chk({req, " index"}, NB'(ctrlIdx), NB'(mIdx));
    chk({req, " packet R7"}, pktData, mPkt);
    if (mValid) begin
      @(negedge clk);
      chk("R10 strobe width", NB'(pktValid), '0);
    end
  endtask

  task automatic sendPacket(input logic [NB-1:0] data, input bit dup);
    doWrite(2'b00, "R2");
    doWrite(2'b11, "R5");
    for (int i = 0; i < NB; i++) begin
      doWrite(data[i] ? 2'b01 : 2'b10, "R4");
      if (dup && ($urandom % 4 == 0)) doWrite(data[i] ? 2'b01 : 2'b10, "R3");
      doWrite(2'b11, "R5");
      if (dup && ($urandom % 6 == 0)) doWrite(2'b11, "R3");
    end
    doWrite(2'b10, "R7");
    chk("R6 packet bit order", pktData, data);
  endtask

  task automatic stepIdx();
    doWrite(2'b01, "R8");
    doWrite(2'b10, "R8");
    doWrite(2'b11, "R8");
  endtask

  initial begin
    logic [NB-1:0] d;
    void'($urandom(32'h1c3a_5eed));
    repeat (3) @(negedge clk);
    chk("R1 valid", NB'(pktValid), '0);
    chk("R1 index", NB'(ctrlIdx), '0);
    chk("R1 packet", pktData, '0);
    rstN = 1'b1;

    // R9 and R4: idle straight after reset, then a one-pulse at pointer -1
    doWrite(2'b11, "R9");
    doWrite(2'b01, "R4");
    doWrite(2'b11, "R5");
    for (int i = 0; i < NB; i++) begin
      doWrite((i % 3 == 0) ? 2'b01 : 2'b10, "R4");
      doWrite(2'b11, "R5");
    end
    doWrite(2'b10, "R7");
    chk("R9 first packet", pktValid ? pktData : pktData, mPkt);

    // R6: single bit in byte 1, bit 0
    d = '0; d[8] = 1'b1;
    sendPacket(d, 0);
    chk("R6 byte 1 bit 0", pktData, NB'(1) << 8);

    // R8: step with mask 3, four times wraps to 0
    idxMask = 2'b11;
    for (int k = 0; k < 4; k++) stepIdx();
    chk("R8 wrap mask 3", NB'(ctrlIdx), '0);
    idxMask = 2'b01;
    stepIdx();
    chk("R8 mask 1 step", NB'(ctrlIdx), NB'(1));
    stepIdx();
    chk("R8 mask 1 wrap", NB'(ctrlIdx), '0);
    idxMask = 2'b00;
    stepIdx();
    chk("R8 mask 0", NB'(ctrlIdx), '0);
    idxMask = 2'b11;

    // R2: bits before a mid-packet reset pulse must not survive
    doWrite(2'b00, "R2");
    doWrite(2'b11, "R5");
    for (int i = 0; i < 20; i++) begin
      doWrite(2'b01, "R4");
      doWrite(2'b11, "R5");
    end
    sendPacket('0, 0);
    chk("R2 cleared packet", pktData, '0);

    // random packets with injected repeats, then controller steps
    for (int p = 0; p < 14; p++) begin
      d = {$urandom, $urandom, $urandom, $urandom};
      sendPacket(d, 1);
      if ($urandom % 2 == 0) stepIdx();
    end

    // unconstrained random writes
    for (int n = 0; n < 600; n++) begin
      if (n % 50 == 0) idxMask = 2'($urandom);
      doWrite(2'($urandom), "R3 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule